// File: doc/BRIEF.md
# BCD calendar clock with alarm

This block keeps wall-clock time as six BCD bytes: seconds, minutes, hours (24-hour), day of month, month and a two-digit year covering 2000 to 2099. It advances once per second. A tick enable arrives at the reference rate of 32768 Hz, and `TICKS_PER_SEC` of these ticks make one second. At each update it pulses event flags for second, minute, hour and day rollovers. Day of month wraps after 28, 29, 30 or 31 depending on month and leap year. The block also holds a six-field alarm that must match the running time exactly.

A small sequencer paces the prescaler and has three states. In `ST_HALT` the clock is stopped. In `ST_COUNT` it counts ticks. `ST_WARN` covers the final tick period before an update, and busy is shown during it. The transitions are:
- HALT to COUNT or WARN when run is set. The target depends on where the prescaler was frozen.
- COUNT to WARN on the tick that leaves one period to go.
- WARN to COUNT on the tick that performs the update.
- Any state to HALT when run is cleared.
- Any state to COUNT (or HALT when not running) on a time load.

Software watches busy and reads or writes the time while busy is low. The alarm is compared once, in the cycle after each update.

Top module: `bcd_cal_clock`

## Requirements
- R1: After reset the time is 00-01-01 00:00:00, and busy, running, all event flags and the alarm hit are low. Time and alarm buses pack fields as year[47:40], month[39:32], day[31:24], hour[23:16], minute[15:8], second[7:0].
- R2: `running_o` follows `run_i` one cycle later. While stopped, ticks change neither the time nor the prescaler position, and counting resumes from the frozen position.
- R3: While running, the time advances by one second on the `TICKS_PER_SEC`-th tick, and `ev_sec_o` is high for exactly the one cycle after that update.
- R4: `busy_o` rises after the (`TICKS_PER_SEC`-1)-th tick of a second and falls with the update tick, so every update is preceded by a busy cycle.
- R5: Each BCD digit carries from 9 to 0. Seconds and minutes wrap 59 to 00 into the next field, raising `ev_min_o` (and `ev_hour_o` when minutes wrap too).
- R6: Hours wrap 23 to 00 and advance the day. `ev_day_o` is raised only together with `ev_hour_o` and `ev_min_o`.
- R7: Months 04, 06, 09 and 11 end after day 30. The other months except February end after day 31. The day then returns to 01 and the month advances.
- R8: February ends after day 29 when the year is divisible by 4 (including 00), otherwise after day 28.
- R9: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.
- R10: A time load replaces all six fields at once, clears busy and restarts the prescaler. The next update comes a full `TICKS_PER_SEC` ticks after the load.
- R11: When an update makes all six time fields equal the stored alarm, `alarm_hit_o` pulses for exactly one cycle, one cycle after the update.
- R12: If any single field differs from the alarm, no hit is raised. No field is ever ignored in the comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | 1 = count, 0 = freeze |
| tick_i | input | 1 | One-cycle enable at the reference rate |
| time_ld_i | input | 1 | Load `time_val_i` into the calendar |
| time_val_i | input | 48 | Time value to load (packed BCD fields) |
| alarm_ld_i | input | 1 | Load `alarm_val_i` into the alarm |
| alarm_val_i | input | 48 | Alarm value to load (packed BCD fields) |
| time_o | output | 48 | Current time (packed BCD fields) |
| running_o | output | 1 | Clock is counting |
| busy_o | output | 1 | Update happens on the next tick |
| ev_sec_o | output | 1 | Second update pulse |
| ev_min_o | output | 1 | Minute rollover pulse |
| ev_hour_o | output | 1 | Hour rollover pulse |
| ev_day_o | output | 1 | Day rollover pulse |
| alarm_hit_o | output | 1 | Alarm match pulse |

## Verification
Most faults in the sequencer show at the ports within one second of ticks. A sequencer stuck in the wrong state, or a prescaler off by one, moves the busy window or the update by a tick. The bench therefore samples busy and the time tick by tick around each update. Faults in the calendar carry chain are visible only at their boundary. For that reason each rollover is reached by loading the time just before it and checking all six fields and all four event flags on the update that follows. A wrong alarm register or comparison shows as a missing or duplicated hit in the two cycles after an update.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

    typedef enum logic [1:0] {
        ST_HALT  = 2'd0,
        ST_COUNT = 2'd1,
        ST_WARN  = 2'd2
    } seq_state_e;

    localparam int FLD_W  = 8;
    localparam int N_FLD  = 6;
    localparam int TIME_W = FLD_W * N_FLD;

    // Field LSB positions inside the packed time bus
    localparam int SEC_LSB  = 0;
    localparam int MIN_LSB  = 8;
    localparam int HOUR_LSB = 16;
    localparam int DAY_LSB  = 24;
    localparam int MON_LSB  = 32;
    localparam int YEAR_LSB = 40;

    // Returns {wrapped, next}. The value wraps to base once it reaches top.
    function automatic logic [8:0] bcd_step(input logic [7:0] v,
                                            input logic [7:0] top,
                                            input logic [7:0] base);
        logic [7:0] n;
        logic       w;
        w = (v >= top);
        if (w)
            n = base;
        else if (v[3:0] >= 4'h9)
            n = {v[7:4] + 4'h1, 4'h0};
        else
            n = {v[7:4], v[3:0] + 4'h1};
        return {w, n};
    endfunction

    // Two-digit BCD year divisible by four
    function automatic logic is_leap(input logic [7:0] y);
        if (y[4])
            return (y[3:0] == 4'h2) || (y[3:0] == 4'h6);
        else
            return (y[3:0] == 4'h0) || (y[3:0] == 4'h4) || (y[3:0] == 4'h8);
    endfunction

    function automatic logic [7:0] month_last(input logic [7:0] m,
                                              input logic [7:0] y);
        logic [7:0] d;
        case (m)
            8'h02:                      d = is_leap(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: d = 8'h30;
            default:                    d = 8'h31;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/bcd_cal_seq.sv
module bcd_cal_seq
    import bcd_cal_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tick_i,
    input  logic restart_i,
    output logic step_o,
    output logic busy_o,
    output logic running_o
);
    localparam int CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CW-1:0] LAST    = CW'(TICKS_PER_SEC - 1);
    localparam logic [CW-1:0] PRELAST = CW'(TICKS_PER_SEC - 2);

    seq_state_e    state, nxt;
    logic [CW-1:0] cnt;
    logic          adv;

    initial begin
        if (TICKS_PER_SEC < 2) $error("TICKS_PER_SEC must be at least 2");
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HALT;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (restart_i)
            nxt = run_i ? ST_COUNT : ST_HALT;
        else if (!run_i)
            nxt = ST_HALT;
        else begin
            unique case (state)
                ST_HALT:  nxt = (cnt == LAST) ? ST_WARN : ST_COUNT;
                ST_COUNT: if (tick_i && cnt == PRELAST) nxt = ST_WARN;
                ST_WARN:  if (tick_i) nxt = ST_COUNT;
                default:  nxt = ST_HALT;
            endcase
        end
    end

    assign adv = run_i && tick_i && !restart_i && (state != ST_HALT);

    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) cnt <= '0;
        else if (adv)            cnt <= (state == ST_WARN) ? '0 : cnt + 1'b1;
    end

    always_comb begin
        step_o    = adv && (state == ST_WARN);
        busy_o    = (state == ST_WARN);
        running_o = (state != ST_HALT);
    end

    // R4: the warning state is only ever held on the last prescaler position
    p_warn_on_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WARN) |-> (cnt == LAST));

endmodule

// File: rtl/bcd_cal_regs.sv
module bcd_cal_regs
    import bcd_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              load_i,
    input  logic [TIME_W-1:0] load_val_i,
    output logic [TIME_W-1:0] time_o,
    output logic              ev_sec_o,
    output logic              ev_min_o,
    output logic              ev_hour_o,
    output logic              ev_day_o
);
    localparam logic [TIME_W-1:0] RESET_TIME = {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

    logic [7:0] sec, mins, hour, day, mon, yr;
    logic [7:0] n_s, n_m, n_h, n_d, n_mo, n_y;
    logic       w_s, w_m, w_h, w_d, w_mo, w_y;
    logic       c_m, c_h, c_d, c_mo, c_y;
    logic [TIME_W-1:0] nxt_time;

    assign sec  = time_o[SEC_LSB  +: 8];
    assign mins = time_o[MIN_LSB  +: 8];
    assign hour = time_o[HOUR_LSB +: 8];
    assign day  = time_o[DAY_LSB  +: 8];
    assign mon  = time_o[MON_LSB  +: 8];
    assign yr   = time_o[YEAR_LSB +: 8];

    always_comb begin
        {w_s,  n_s}  = bcd_step(sec,  8'h59, 8'h00);
        {w_m,  n_m}  = bcd_step(mins, 8'h59, 8'h00);
        {w_h,  n_h}  = bcd_step(hour, 8'h23, 8'h00);
        {w_d,  n_d}  = bcd_step(day,  month_last(mon, yr), 8'h01);
        {w_mo, n_mo} = bcd_step(mon,  8'h12, 8'h01);
        {w_y,  n_y}  = bcd_step(yr,   8'h99, 8'h00);
        c_m  = w_s;
        c_h  = c_m && w_m;
        c_d  = c_h && w_h;
        c_mo = c_d && w_d;
        c_y  = c_mo && w_mo;
        nxt_time = {c_y  ? n_y  : yr,
                    c_mo ? n_mo : mon,
                    c_d  ? n_d  : day,
                    c_h  ? n_h  : hour,
                    c_m  ? n_m  : mins,
                    n_s};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_o    <= RESET_TIME;
            ev_sec_o  <= 1'b0;
            ev_min_o  <= 1'b0;
            ev_hour_o <= 1'b0;
            ev_day_o  <= 1'b0;
        end else if (load_i) begin
            time_o    <= load_val_i;
            ev_sec_o  <= 1'b0;
            ev_min_o  <= 1'b0;
            ev_hour_o <= 1'b0;
            ev_day_o  <= 1'b0;
        end else begin
            if (step_i) time_o <= nxt_time;
            ev_sec_o  <= step_i;
            ev_min_o  <= step_i && c_m;
            ev_hour_o <= step_i && c_h;
            ev_day_o  <= step_i && c_d;
        end
    end

    // R6: a day rollover always comes with hour and minute rollovers
    p_day_with_hour_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_day_o |-> (ev_hour_o && ev_min_o && ev_sec_o));

    // R6: on a day event the hours have just wrapped to 00
    p_day_hour_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_day_o |-> (hour == 8'h00));

endmodule

// File: rtl/bcd_cal_alarm.sv
module bcd_cal_alarm
    import bcd_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_i,
    input  logic [TIME_W-1:0] val_i,
    input  logic [TIME_W-1:0] time_i,
    input  logic              strobe_i,
    output logic              hit_o
);
    logic [TIME_W-1:0] alarm_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q <= '0;
            hit_o   <= 1'b0;
        end else begin
            if (ld_i) alarm_q <= val_i;
            hit_o <= strobe_i && (time_i == alarm_q);
        end
    end

    // R11: a hit only follows an update strobe
    p_hit_after_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> $past(strobe_i));

    // R11: a hit lasts a single cycle
    p_hit_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> !hit_o);

endmodule

// File: rtl/bcd_cal_clock.sv
module bcd_cal_clock
    import bcd_cal_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run_i,
    input  logic        tick_i,
    input  logic        time_ld_i,
    input  logic [47:0] time_val_i,
    input  logic        alarm_ld_i,
    input  logic [47:0] alarm_val_i,
    output logic [47:0] time_o,
    output logic        running_o,
    output logic        busy_o,
    output logic        ev_sec_o,
    output logic        ev_min_o,
    output logic        ev_hour_o,
    output logic        ev_day_o,
    output logic        alarm_hit_o
);
    logic step;

    bcd_cal_seq #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run_i),
        .tick_i    (tick_i),
        .restart_i (time_ld_i),
        .step_o    (step),
        .busy_o    (busy_o),
        .running_o (running_o)
    );

    bcd_cal_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_i     (step),
        .load_i     (time_ld_i),
        .load_val_i (time_val_i),
        .time_o     (time_o),
        .ev_sec_o   (ev_sec_o),
        .ev_min_o   (ev_min_o),
        .ev_hour_o  (ev_hour_o),
        .ev_day_o   (ev_day_o)
    );

    bcd_cal_alarm u_alarm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_i     (alarm_ld_i),
        .val_i    (alarm_val_i),
        .time_i   (time_o),
        .strobe_i (ev_sec_o),
        .hit_o    (alarm_hit_o)
    );

    // R4: every update was preceded by a busy cycle
    p_update_after_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_sec_o |-> $past(busy_o));

    // R2: a stopped clock keeps its time unless loaded
    p_frozen_when_halted_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!running_o && !time_ld_i) |=> $stable(time_o));

endmodule

// File: tb/bcd_cal_clock_tb.sv
module bcd_cal_clock_tb;
    localparam int TPS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_i = 1'b0;
    logic        tick_i = 1'b0;
    logic        time_ld_i = 1'b0;
    logic [47:0] time_val_i = '0;
    logic        alarm_ld_i = 1'b0;
    logic [47:0] alarm_val_i = '0;
    logic [47:0] time_o;
    logic        running_o, busy_o, ev_sec_o, ev_min_o, ev_hour_o, ev_day_o, alarm_hit_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bcd_cal_clock #(.TICKS_PER_SEC(TPS)) u_dut (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .tick_i(tick_i),
        .time_ld_i(time_ld_i), .time_val_i(time_val_i),
        .alarm_ld_i(alarm_ld_i), .alarm_val_i(alarm_val_i),
        .time_o(time_o), .running_o(running_o), .busy_o(busy_o),
        .ev_sec_o(ev_sec_o), .ev_min_o(ev_min_o), .ev_hour_o(ev_hour_o),
        .ev_day_o(ev_day_o), .alarm_hit_o(alarm_hit_o)
    );

    function automatic logic [47:0] tm(input logic [7:0] y, mo, d, h, mi, s);
        return {y, mo, d, h, mi, s};
    endfunction

    task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [47:0] evs();
        return {44'd0, ev_day_o, ev_hour_o, ev_min_o, ev_sec_o};
    endfunction

    task automatic do_tick();
        @(negedge clk) tick_i = 1'b1;
        @(negedge clk) tick_i = 1'b0;
    endtask

    task automatic load_time(input logic [47:0] v);
        @(negedge clk) begin time_val_i = v; time_ld_i = 1'b1; end
        @(negedge clk) time_ld_i = 1'b0;
    endtask

    task automatic load_alarm(input logic [47:0] v);
        @(negedge clk) begin alarm_val_i = v; alarm_ld_i = 1'b1; end
        @(negedge clk) alarm_ld_i = 1'b0;
    endtask

    // Load start, run one full second, check time and {day,hour,min,sec} events
    task automatic roll(input string tag, input logic [47:0] start,
                        input logic [47:0] exp, input logic [3:0] ev_exp);
        load_time(start);
        repeat (TPS) do_tick();
        chk({tag, " time"}, time_o, exp);
        chk({tag, " events"}, evs(), {44'd0, ev_exp});
    endtask

    task automatic t_reset();
        chk("R1 reset time", time_o, tm(8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00));
        chk("R1 reset flags", {41'd0, running_o, busy_o, ev_sec_o, ev_min_o, ev_hour_o, ev_day_o, alarm_hit_o}, '0);
    endtask

    task automatic t_stopped();
        repeat (2 * TPS) do_tick();
        chk("R2 stopped time", time_o, tm(8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00));
        chk("R2 stopped running", {47'd0, running_o}, 48'd0);
        @(negedge clk) run_i = 1'b1;
        @(negedge clk);
        chk("R2 running after run", {47'd0, running_o}, 48'd1);
    endtask

    task automatic t_busy();
        load_time(tm(8'h13, 8'h06, 8'h15, 8'h10, 8'h20, 8'h30));
        chk("R4 busy low after load", {47'd0, busy_o}, 48'd0);
        repeat (TPS - 2) do_tick();
        chk("R4 busy low before last period", {47'd0, busy_o}, 48'd0);
        chk("R3 time held before second", time_o, tm(8'h13, 8'h06, 8'h15, 8'h10, 8'h20, 8'h30));
        do_tick();
        chk("R4 busy high in last period", {47'd0, busy_o}, 48'd1);
        do_tick();
        chk("R4 busy low after update", {47'd0, busy_o}, 48'd0);
        chk("R3 second advanced", time_o, tm(8'h13, 8'h06, 8'h15, 8'h10, 8'h20, 8'h31));
        chk("R3 ev_sec high", evs(), 48'h1);
        @(negedge clk);
        chk("R3 ev_sec single cycle", evs(), 48'h0);
    endtask

    task automatic t_load_restart();
        load_time(tm(8'h20, 8'h03, 8'h03, 8'h03, 8'h03, 8'h03));
        repeat (TPS - 1) do_tick();
        load_time(tm(8'h21, 8'h07, 8'h07, 8'h07, 8'h07, 8'h07));
        chk("R10 busy cleared by load", {47'd0, busy_o}, 48'd0);
        repeat (TPS - 1) do_tick();
        chk("R10 no early update", time_o, tm(8'h21, 8'h07, 8'h07, 8'h07, 8'h07, 8'h07));
        do_tick();
        chk("R10 full second after load", time_o, tm(8'h21, 8'h07, 8'h07, 8'h07, 8'h07, 8'h08));
    endtask

    task automatic t_stop_resume();
        load_time(tm(8'h30, 8'h01, 8'h01, 8'h01, 8'h01, 8'h01));
        repeat (TPS - 2) do_tick();
        @(negedge clk) run_i = 1'b0;
        @(negedge clk);
        chk("R2 running low after stop", {47'd0, running_o}, 48'd0);
        repeat (2 * TPS) do_tick();
        chk("R2 frozen while stopped", time_o, tm(8'h30, 8'h01, 8'h01, 8'h01, 8'h01, 8'h01));
        @(negedge clk) run_i = 1'b1;
        @(negedge clk);
        do_tick();
        chk("R2 resume keeps position busy", {47'd0, busy_o}, 48'd1);
        do_tick();
        chk("R2 resume completes second", time_o, tm(8'h30, 8'h01, 8'h01, 8'h01, 8'h01, 8'h02));
    endtask

    task automatic t_carry();
        roll("R5 digit carry", tm(8'h14, 8'h05, 8'h05, 8'h05, 8'h05, 8'h09),
             tm(8'h14, 8'h05, 8'h05, 8'h05, 8'h05, 8'h10), 4'b0001);
        roll("R5 minute rollover", tm(8'h14, 8'h05, 8'h05, 8'h05, 8'h19, 8'h59),
             tm(8'h14, 8'h05, 8'h05, 8'h05, 8'h20, 8'h00), 4'b0011);
        roll("R5 hour rollover", tm(8'h14, 8'h05, 8'h05, 8'h12, 8'h59, 8'h59),
             tm(8'h14, 8'h05, 8'h05, 8'h13, 8'h00, 8'h00), 4'b0111);
        roll("R6 day rollover", tm(8'h14, 8'h05, 8'h09, 8'h23, 8'h59, 8'h59),
             tm(8'h14, 8'h05, 8'h10, 8'h00, 8'h00, 8'h00), 4'b1111);
    endtask

    task automatic t_months();
        roll("R7 30-day month", tm(8'h13, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59),
             tm(8'h13, 8'h05, 8'h01, 8'h00, 8'h00, 8'h00), 4'b1111);
        roll("R7 31-day month no wrap at 30", tm(8'h13, 8'h01, 8'h30, 8'h23, 8'h59, 8'h59),
             tm(8'h13, 8'h01, 8'h31, 8'h00, 8'h00, 8'h00), 4'b1111);
        roll("R7 31-day month", tm(8'h13, 8'h10, 8'h31, 8'h23, 8'h59, 8'h59),
             tm(8'h13, 8'h11, 8'h01, 8'h00, 8'h00, 8'h00), 4'b1111);
        roll("R7 november", tm(8'h13, 8'h11, 8'h30, 8'h23, 8'h59, 8'h59),
             tm(8'h13, 8'h12, 8'h01, 8'h00, 8'h00, 8'h00), 4'b1111);
    endtask

    task automatic t_feb();
        roll("R8 common feb", tm(8'h13, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59),
             tm(8'h13, 8'h03, 8'h01, 8'h00, 8'h00, 8'h00), 4'b1111);
        roll("R8 leap feb 28", tm(8'h12, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59),
             tm(8'h12, 8'h02, 8'h29, 8'h00, 8'h00, 8'h00), 4'b1111);
        roll("R8 leap feb 29", tm(8'h96, 8'h02, 8'h29, 8'h23, 8'h59, 8'h59),
             tm(8'h96, 8'h03, 8'h01, 8'h00, 8'h00, 8'h00), 4'b1111);
        roll("R8 year 00 leap", tm(8'h00, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59),
             tm(8'h00, 8'h02, 8'h29, 8'h00, 8'h00, 8'h00), 4'b1111);
        roll("R8 year 10 common", tm(8'h10, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59),
             tm(8'h10, 8'h03, 8'h01, 8'h00, 8'h00, 8'h00), 4'b1111);
    endtask

    task automatic t_year();
        roll("R9 new year", tm(8'h19, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59),
             tm(8'h20, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00), 4'b1111);
        roll("R9 century wrap", tm(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59),
             tm(8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00), 4'b1111);
    endtask

    task automatic t_alarm_hit();
        load_alarm(tm(8'h25, 8'h08, 8'h17, 8'h06, 8'h30, 8'h00));
        load_time(tm(8'h25, 8'h08, 8'h17, 8'h06, 8'h29, 8'h59));
        repeat (TPS) do_tick();
        chk("R11 no hit in update cycle", {47'd0, alarm_hit_o}, 48'd0);
        @(negedge clk);
        chk("R11 hit one cycle after update", {47'd0, alarm_hit_o}, 48'd1);
        @(negedge clk);
        chk("R11 hit single cycle", {47'd0, alarm_hit_o}, 48'd0);
        repeat (TPS) do_tick();
        @(negedge clk);
        chk("R11 no hit on next second", {47'd0, alarm_hit_o}, 48'd0);
    endtask

    task automatic t_alarm_miss();
        load_alarm(tm(8'h26, 8'h08, 8'h17, 8'h06, 8'h30, 8'h00));
        load_time(tm(8'h25, 8'h08, 8'h17, 8'h06, 8'h29, 8'h59));
        repeat (TPS) do_tick();
        @(negedge clk);
        chk("R12 year mismatch no hit", {47'd0, alarm_hit_o}, 48'd0);
        load_alarm(tm(8'h25, 8'h09, 8'h17, 8'h06, 8'h30, 8'h00));
        load_time(tm(8'h25, 8'h08, 8'h17, 8'h06, 8'h29, 8'h59));
        repeat (TPS) do_tick();
        @(negedge clk);
        chk("R12 month mismatch no hit", {47'd0, alarm_hit_o}, 48'd0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stopped();
        t_busy();
        t_load_restart();
        t_stop_resume();
        t_carry();
        t_months();
        t_feb();
        t_year();
        t_alarm_hit();
        t_alarm_miss();
        done = 1;
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

endmodule